// File: doc/BRIEF.md
# Periodic Framed Telemetry Transmitter

This block pushes one block of measurement bytes onto a half-duplex RS-485 line at a fixed interval, with no per-byte help from a processor. A host describes the block once: a base address and a byte count in a byte-wide buffer. From then on an internal interval counter starts every frame. A fetch sequencer reads the buffer through a synchronous port and a CRC-16 unit folds in every payload byte. An 8N1 serializer shifts the whole frame out and also drives the transceiver's output-enable pin.

A frame on the wire is the sync pair 0xEB then 0x90, then the payload bytes in ascending address order, then the CRC-16 of the payload, high byte first. The bit time is set by a divider input, counted in clock cycles. The interval is a parameter, 500,000 cycles by default, which is 10 ms at 50 MHz. The default payload length is 72 bytes. If a frame is still on the line when the next interval starts, that start is dropped and a sticky flag records the loss.

Top module: `telem_framer`

## Requirements
- R1: After reset `txd` is high, `drv_en` is low, `overrun` is low, and no buffer read is issued until the first interval expires.
- R2: When no frame overruns, successive rising edges of `drv_en` are exactly `PERIOD_CYC` clock cycles apart.
- R3: Every byte is sent as one low start bit, eight data bits with the LSB first, and one high stop bit. Each bit lasts `baud_div` clock cycles, sampled when the frame starts.
- R4: A frame carries 0xEB, 0x90, and then the bytes at `base`, `base+1`, …, `base+len-1`, in that order.
- R5: The last two bytes are the CRC-16 over the payload bytes only. The polynomial is 0x1021, the seed is 0xFFFF, each byte is taken MSB first, and the high byte is sent first. The payload "123456789" gives 0x29 then 0xB1.
- R6: `drv_en` rises exactly one bit time before the first start bit falls. It falls exactly one bit time after the last stop bit ends.
- R7: Within a frame the next start bit begins at the very cycle the previous stop bit ends.
- R8: Out of reset the base is 0 and the length is 72. A `host_load` pulse replaces both values. Values loaded while a frame is on the line change only later frames.
- R9: An interval that expires while a frame is in progress starts no frame and sets `overrun`. The next frame then starts one interval later. `overrun` stays set until an `ovr_clr` pulse, and a new overrun has priority over a clear in the same cycle.
- R10: Buffer reads are single-cycle `mem_rd_en` pulses, never on two consecutive cycles. Read data is taken on the cycle after the pulse. Each frame issues exactly `len` reads.
- R11: A length of zero yields a four-byte frame: 0xEB, 0x90, 0xFF, 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Clock cycles per bit, 1 or more |
| host_load | input | 1 | Pulse that loads `host_base` and `host_len` |
| host_base | input | ADDR_W | Buffer address of the first payload byte |
| host_len | input | LEN_W | Payload byte count |
| ovr_clr | input | 1 | Pulse that clears the overrun flag |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_rd_addr | output | ADDR_W | Buffer read address |
| mem_rd_data | input | 8 | Buffer read data, valid one cycle after the strobe |
| txd | output | 1 | Serial data toward the transceiver, idles high |
| drv_en | output | 1 | Transceiver driver enable |
| overrun | output | 1 | Sticky flag for a dropped interval |

## Verification
The hardest case to reach from the ports is an interval that expires while a frame is still on the line. The bench makes it happen by loading a payload long enough that one frame outlasts the interval. It then checks that the next frame starts two intervals after the last one and that the flag both sets and clears. A second awkward case is a host write that lands in the middle of a frame. The bench times that write from the observed rise of `drv_en`, then checks that the current frame is unchanged and that the next frame uses the new values. The baud rate is switched between frames, so the bit-time and direction-margin checks run at more than one divider value.

// File: rtl/telem_pkg.sv
package telem_pkg;

    localparam logic [7:0]  SYNC_A   = 8'hEB;
    localparam logic [7:0]  SYNC_B   = 8'h90;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SYNC_A,
        SQ_SYNC_B,
        SQ_BODY,
        SQ_SUM_HI,
        SQ_SUM_LO
    } seq_st_e;

    typedef enum logic [2:0] {
        LN_IDLE,
        LN_LEAD,
        LN_START,
        LN_DATA,
        LN_STOP,
        LN_TRAIL
    } line_st_e;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
    } lane_byte_t;

    // One byte of CRC-16, most significant data bit first.
    function automatic logic [15:0] crc16_step(logic [15:0] c, logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/tf_tick_gen.sv
module tf_tick_gen #(
    parameter int PERIOD_CYC = 500000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0)); // R2

endmodule

// File: rtl/tf_crc16.sv
module tf_crc16
    import telem_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clear) crc <= CRC_SEED;
        else if (en)      crc <= crc16_step(crc, data);
    end
endmodule

// File: rtl/tf_line_tx.sv
module tf_line_tx
    import telem_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  lane_byte_t       nx,
    input  logic             nx_valid,
    output logic             nx_take,
    output logic             txd,
    output logic             drv_en,
    output logic             busy
);
    line_st_e         st;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             last_q;
    logic             tdone;

    assign tdone = (cnt == '0);

    always_comb begin
        nx_take = nx_valid && tdone &&
                  ((st == LN_LEAD) || ((st == LN_STOP) && !last_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= LN_IDLE;
            cnt    <= '0;
            div_q  <= '0;
            bitn   <= '0;
            sh     <= '0;
            last_q <= 1'b0;
        end else begin
            case (st)
                LN_IDLE: begin
                    if (nx_valid) begin
                        st    <= LN_LEAD;
                        div_q <= div;
                        cnt   <= div - DIV_W'(1);
                    end
                end
                LN_LEAD: begin
                    if (tdone) begin
                        st     <= LN_START;
                        cnt    <= div_q - DIV_W'(1);
                        sh     <= nx.data;
                        last_q <= nx.last;
                    end else cnt <= cnt - DIV_W'(1);
                end
                LN_START: begin
                    if (tdone) begin
                        st   <= LN_DATA;
                        bitn <= '0;
                        cnt  <= div_q - DIV_W'(1);
                    end else cnt <= cnt - DIV_W'(1);
                end
                LN_DATA: begin
                    if (tdone) begin
                        cnt <= div_q - DIV_W'(1);
                        if (bitn == 3'd7) st <= LN_STOP;
                        else begin
                            bitn <= bitn + 3'd1;
                            sh   <= {1'b0, sh[7:1]};
                        end
                    end else cnt <= cnt - DIV_W'(1);
                end
                LN_STOP: begin
                    if (tdone) begin
                        if (last_q) begin
                            st  <= LN_TRAIL;
                            cnt <= div_q - DIV_W'(1);
                        end else if (nx_valid) begin
                            st     <= LN_START;
                            cnt    <= div_q - DIV_W'(1);
                            sh     <= nx.data;
                            last_q <= nx.last;
                        end
                    end else cnt <= cnt - DIV_W'(1);
                end
                LN_TRAIL: begin
                    if (tdone) st <= LN_IDLE;
                    else       cnt <= cnt - DIV_W'(1);
                end
                default: st <= LN_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st)
            LN_START: txd = 1'b0;
            LN_DATA:  txd = sh[0];
            default:  txd = 1'b1;
        endcase
    end

    assign drv_en = (st != LN_IDLE);
    assign busy   = drv_en;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> txd); // R1

    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        ((st == LN_STOP) && tdone && !last_q) |-> nx_valid); // R7

endmodule

// File: rtl/telem_framer.sv
module telem_framer
    import telem_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LEN_W      = 10,
    parameter int DIV_W      = 16,
    parameter int PERIOD_CYC = 500000,
    parameter int RST_LEN    = 72
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              host_load,
    input  logic [ADDR_W-1:0] host_base,
    input  logic [LEN_W-1:0]  host_len,
    input  logic              ovr_clr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              txd,
    output logic              drv_en,
    output logic              overrun
);
    localparam logic [LEN_W-1:0] LEN_RST = LEN_W'(RST_LEN);

    logic [ADDR_W-1:0] base_r, base_f;
    logic [LEN_W-1:0]  len_r, len_f, idx;
    logic              tick, busy, start;
    logic              ser_busy, take;
    logic              rd_pend;
    logic              hold_v;
    lane_byte_t        hold;
    seq_st_e           sq;
    logic [15:0]       crc;

    // Host-visible frame description
    always_ff @(posedge clk) begin
        if (rst) begin
            base_r <= '0;
            len_r  <= LEN_RST;
        end else if (host_load) begin
            base_r <= host_base;
            len_r  <= host_len;
        end
    end

    tf_tick_gen #(.PERIOD_CYC(PERIOD_CYC)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    assign busy  = (sq != SQ_IDLE) || ser_busy;
    assign start = tick && !busy;

    always_ff @(posedge clk) begin
        if (rst)                overrun <= 1'b0;
        else if (tick && busy)  overrun <= 1'b1;
        else if (ovr_clr)       overrun <= 1'b0;
    end

    assign mem_rd_en   = (sq == SQ_BODY) && !hold_v && !rd_pend && (idx != len_f);
    assign mem_rd_addr = base_f + ADDR_W'(idx);

    tf_crc16 u_crc (
        .clk  (clk),
        .rst  (rst),
        .clear(start),
        .en   (rd_pend),
        .data (mem_rd_data),
        .crc  (crc)
    );

    // Fetch sequencer: keeps one byte queued ahead of the serializer
    always_ff @(posedge clk) begin
        if (rst) begin
            sq      <= SQ_IDLE;
            rd_pend <= 1'b0;
            hold_v  <= 1'b0;
            hold    <= '0;
            idx     <= '0;
            base_f  <= '0;
            len_f   <= '0;
        end else begin
            rd_pend <= mem_rd_en;
            if (take) hold_v <= 1'b0;
            case (sq)
                SQ_IDLE: begin
                    if (start) begin
                        sq     <= SQ_SYNC_A;
                        base_f <= base_r;
                        len_f  <= len_r;
                        idx    <= '0;
                    end
                end
                SQ_SYNC_A: begin
                    if (!hold_v) begin
                        hold   <= '{data: SYNC_A, last: 1'b0};
                        hold_v <= 1'b1;
                        sq     <= SQ_SYNC_B;
                    end
                end
                SQ_SYNC_B: begin
                    if (!hold_v) begin
                        hold   <= '{data: SYNC_B, last: 1'b0};
                        hold_v <= 1'b1;
                        sq     <= SQ_BODY;
                    end
                end
                SQ_BODY: begin
                    if (rd_pend) begin
                        hold   <= '{data: mem_rd_data, last: 1'b0};
                        hold_v <= 1'b1;
                        idx    <= idx + 1'b1;
                    end else if (idx == len_f) begin
                        sq <= SQ_SUM_HI;
                    end
                end
                SQ_SUM_HI: begin
                    if (!hold_v) begin
                        hold   <= '{data: crc[15:8], last: 1'b0};
                        hold_v <= 1'b1;
                        sq     <= SQ_SUM_LO;
                    end
                end
                SQ_SUM_LO: begin
                    if (!hold_v) begin
                        hold   <= '{data: crc[7:0], last: 1'b1};
                        hold_v <= 1'b1;
                        sq     <= SQ_IDLE;
                    end
                end
                default: sq <= SQ_IDLE;
            endcase
        end
    end

    tf_line_tx #(.DIV_W(DIV_W)) u_line (
        .clk     (clk),
        .rst     (rst),
        .div     (baud_div),
        .nx      (hold),
        .nx_valid(hold_v),
        .nx_take (take),
        .txd     (txd),
        .drv_en  (drv_en),
        .busy    (ser_busy)
    );

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en); // R10

    AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (sq == SQ_IDLE) |-> !mem_rd_en); // R10

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun); // R9

    AST_SKIP_TICK: assert property (@(posedge clk) disable iff (rst)
        (tick && busy) |=> (overrun && $stable(sq))); // R9

    AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ((sq == SQ_SUM_HI) || (sq == SQ_SUM_LO)) |-> !rd_pend); // R5

endmodule

// File: tb/sim_telem_framer.sv
module sim_telem_framer;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 4000;
    localparam int ADDR_W     = 12;
    localparam int LEN_W      = 10;
    localparam int DIV_W      = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DIV_W-1:0]  baud_div;
    logic              host_load = 1'b0;
    logic [ADDR_W-1:0] host_base = '0;
    logic [LEN_W-1:0]  host_len = '0;
    logic              ovr_clr = 1'b0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [7:0]        mem_rd_data = 8'h00;
    logic              txd, drv_en, overrun;

    int checks = 0;
    int errs = 0;
    int cyc = 0;
    int div_cur = 4;
    int frames_done = 0;
    int rd_total = 0;
    int b2b_reads = 0;
    bit prev_rd = 1'b0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    int         flen_q[$];
    int         fgap_q[$];
    int         fpay_q[$];
    string      ftag_q[$];

    assign baud_div = DIV_W'(div_cur);

    always #(CLK_PERIOD/2) clk = ~clk;

    telem_framer #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DIV_W(DIV_W),
        .PERIOD_CYC(PERIOD), .RST_LEN(72)
    ) u0 (
        .clk(clk), .rst(rst), .baud_div(baud_div),
        .host_load(host_load), .host_base(host_base), .host_len(host_len),
        .ovr_clr(ovr_clr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .txd(txd), .drv_en(drv_en), .overrun(overrun)
    );

    function automatic logic [7:0] byte_at(int a);
        if (a >= 256 && a < 265) return 8'(8'h31 + (a - 256));
        return 8'((a * 13 + 5) ^ (a >> 4));
    endfunction

    function automatic logic [15:0] ref_crc(int base, int len);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int k = 0; k < len; k++) begin
            c = c ^ {byte_at((base + k) % 4096), 8'h00};
            for (int j = 0; j < 8; j++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    endtask

    // Scoreboard driver: push the bytes a frame must carry
    task automatic expect_frame(int base, int len, int gap, string tag,
                                bit use_lit, logic [15:0] lit);
        logic [15:0] c;
        c = use_lit ? lit : ref_crc(base, len);
        exp_q.push_back(8'hEB);
        exp_q.push_back(8'h90);
        for (int k = 0; k < len; k++) exp_q.push_back(byte_at((base + k) % 4096));
        exp_q.push_back(c[15:8]);
        exp_q.push_back(c[7:0]);
        flen_q.push_back(len + 4);
        fpay_q.push_back(len);
        fgap_q.push_back(gap);
        ftag_q.push_back(tag);
    endtask

    task automatic load_cfg(int base, int len);
        @(negedge clk);
        host_base = ADDR_W'(base);
        host_len  = LEN_W'(len);
        host_load = 1'b1;
        @(negedge clk);
        host_load = 1'b0;
    endtask

    // Buffer model, one-cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) begin
            mem_rd_data <= byte_at(int'(mem_rd_addr));
            rd_total    <= rd_total + 1;
        end
        if (!rst && mem_rd_en && prev_rd) b2b_reads <= b2b_reads + 1;
        prev_rd <= mem_rd_en;
    end

    // Monitor: decode the line and compare against the scoreboard
    initial begin : monitor
        int prev_rise;
        prev_rise = -1;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            int rise, n, gap, pay, lead, trail, rd0;
            string tag;
            while (!drv_en) @(negedge clk);
            rise = cyc;
            rd0  = rd_total;
            if (flen_q.size() == 0) begin
                check(0, "R2", "unexpected frame start", rise, 0);
                n = 0; gap = 0; pay = 0; tag = "";
            end else begin
                n   = flen_q.pop_front();
                gap = fgap_q.pop_front();
                pay = fpay_q.pop_front();
                tag = ftag_q.pop_front();
            end
            if (gap > 0)
                check((rise - prev_rise) == gap, (gap > PERIOD) ? "R9" : "R2",
                      "frame start spacing", rise - prev_rise, gap);
            prev_rise = rise;
            lead = 0;
            while (txd && drv_en) begin lead++; @(negedge clk); end
            check(lead == div_cur, "R6", "enable lead cycles", lead, div_cur);
            for (int b = 0; b < n; b++) begin
                logic [7:0] v;
                logic [7:0] e;
                string      rq;
                if (b > 0) check(txd == 1'b0, "R7", "start bit right after stop", txd, 0);
                repeat (div_cur + div_cur / 2) @(negedge clk);
                v[0] = txd;
                for (int i = 1; i < 8; i++) begin
                    repeat (div_cur) @(negedge clk);
                    v[i] = txd;
                end
                repeat (div_cur) @(negedge clk);
                check(txd == 1'b1, "R3", "stop bit level", txd, 1);
                e  = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
                rq = (tag != "") ? tag : ((b >= n - 2) ? "R5" : "R4");
                check(v == e, rq, $sformatf("frame byte %0d", b), v, e);
                repeat (div_cur - div_cur / 2) @(negedge clk);
            end
            trail = 0;
            while (drv_en) begin
                if (!txd) check(0, "R6", "line low during trail", txd, 1);
                trail++;
                @(negedge clk);
            end
            check(trail == div_cur, "R6", "enable trail cycles", trail, div_cur);
            check((rd_total - rd0) == pay, "R10", "reads per frame", rd_total - rd0, pay);
            check(b2b_reads == 0, "R10", "back-to-back reads", b2b_reads, 0);
            frames_done++;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R2", "watchdog expired, frames seen", frames_done, 9);
        finish_run();
    end

    // Stimulus
    initial begin
        expect_frame(0, 72, 0, "R8", 1'b0, 16'h0);
        expect_frame(0, 72, PERIOD, "R8", 1'b0, 16'h0);
        repeat (5) @(negedge clk);
        check(txd == 1'b1, "R1", "txd in reset", txd, 1);
        check(drv_en == 1'b0, "R1", "drv_en in reset", drv_en, 0);
        check(overrun == 1'b0, "R1", "overrun in reset", overrun, 0);
        rst = 1'b0;
        begin
            int bad;
            bad = 0;
            repeat (200) begin
                @(negedge clk);
                if (drv_en || mem_rd_en || !txd) bad++;
            end
            check(bad == 0, "R1", "quiet line before first interval", bad, 0);
        end

        // Mid-frame host write must only affect the next frame
        wait (frames_done == 1);
        @(negedge clk);
        while (!drv_en) @(negedge clk);
        repeat (200) @(negedge clk);
        load_cfg(256, 9);
        expect_frame(256, 9, PERIOD, "", 1'b1, 16'h29B1);

        wait (frames_done == 3);
        load_cfg(5, 0);
        expect_frame(5, 0, PERIOD, "R11", 1'b0, 16'h0);

        wait (frames_done == 4);
        div_cur = 6;
        load_cfg(12'h7F0, 20);
        expect_frame(12'h7F0, 20, PERIOD, "R3", 1'b0, 16'h0);

        wait (frames_done == 5);
        div_cur = 4;
        load_cfg(12'h200, 120);
        expect_frame(12'h200, 120, PERIOD, "", 1'b0, 16'h0);

        wait (frames_done == 6);
        @(negedge clk);
        check(overrun == 1'b1, "R9", "overrun after long frame", overrun, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check(overrun == 1'b0, "R9", "overrun after clear", overrun, 0);
        expect_frame(12'h200, 120, 2 * PERIOD, "", 1'b0, 16'h0);
        while (!drv_en) @(negedge clk);
        repeat (100) @(negedge clk);
        load_cfg(12'h300, 10);
        expect_frame(12'h300, 10, 2 * PERIOD, "", 1'b0, 16'h0);

        wait (frames_done == 7);
        @(negedge clk);
        check(overrun == 1'b1, "R9", "overrun set again", overrun, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;

        wait (frames_done == 8);
        @(negedge clk);
        check(overrun == 1'b0, "R9", "no overrun for short frame", overrun, 0);
        expect_frame(12'h300, 10, PERIOD, "R4", 1'b0, 16'h0);

        wait (frames_done == 9);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4", "bytes left in scoreboard", exp_q.size(), 0);
        finish_run();
    end
endmodule